// File: doc/BRIEF.md
# Transceiver status flag manager

This block keeps the status flags of a bus transceiver and presents one of them at a time on a single active-low error pin. Which flag appears depends on the effective operating mode. In Normal mode it also depends on how many dominant-to-recessive transitions the transmit line has made since Normal mode was entered. Each flag has its own set and clear rules.

The block also watches a supply-undervoltage indication. When the indication persists, the block latches an undervoltage flag and forces the effective mode to Sleep, whatever mode is requested. Analogue sensing is done elsewhere. The block sees only logic-level event and condition inputs, and all timing is in clock cycles.

The mode encoding is 2'b00 Normal, 2'b01 Listen-only, 2'b10 Standby and 2'b11 Sleep. On both line inputs, 0 means dominant and 1 means recessive.

Top module: `xcvr_flag_mgr`

## Requirements
- R1: After reset all flags are clear, so `err_n_o` is 1, `force_sleep_o` is 0 and `wake_o` is 0.
- R2: In Normal mode, `err_n_o` shows the inverted wake-source flag until the fourth 0-to-1 transition of `txd_i` is counted, and shows the inverted bus-failure flag from then on. The transition counter saturates at four and restarts from zero on every entry into Normal mode.
- R3: In Listen-only mode entered directly from Normal, `err_n_o` shows the local-failure flag. In Listen-only mode entered any other way, it shows the power-on flag. In Standby and Sleep, it shows the wake flag.
- R4: A wake event with `wake_remote_i`=0 sets the wake-source flag, and a remote wake event does not. The wake-source flag clears on leaving Normal mode. Any wake event sets the wake flag, which clears on entering Normal mode.
- R5: A `bus_fail_i` pulse sets the bus-failure flag. The flag clears on entering Normal mode or on a power-on event.
- R6: `local_fail_i` sets the local-failure flag. The flag clears on entering Normal mode, on a power-on event, or in a cycle with `rxd_i`=0, `txd_i`=1 and `local_fail_i`=0.
- R7: The undervoltage flag sets after `uv_supply_i` has been high on DET_CYC consecutive clock edges. While the flag is set, `force_sleep_o` is 1 and the effective mode is Sleep.
- R8: The undervoltage flag and both of its timers clear on any wake event, on a power-on event, on a 0-to-1 transition of `stb_n_i`, or after `uv_supply_i` has been low on REC_CYC consecutive edges.
- R9: A power-on event sets the power-on, wake and wake-source flags, even if a clear condition for them occurs in the same cycle. The power-on flag clears on entering Normal mode.
- R10: For the bus-failure and local-failure flags, a clear condition wins over a set condition in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Requested mode: 0 Normal, 1 Listen-only, 2 Standby, 3 Sleep |
| wake_evt_i | input | 1 | One-cycle wake-up event |
| wake_remote_i | input | 1 | Source of the wake event: 1 remote (bus), 0 local |
| uv_supply_i | input | 1 | Supply undervoltage condition, sampled each cycle |
| pwon_evt_i | input | 1 | One-cycle battery power-on event |
| bus_fail_i | input | 1 | Bus failure detector output |
| local_fail_i | input | 1 | Local failure present |
| txd_i | input | 1 | Transmit line level, 0 dominant |
| rxd_i | input | 1 | Receive line level, 0 dominant |
| stb_n_i | input | 1 | Standby control pin |
| err_n_o | output | 1 | Active-low selected flag |
| force_sleep_o | output | 1 | Undervoltage flag, which forces Sleep mode |
| wake_o | output | 1 | Wake flag |

## Verification
A set condition and a clear condition for the same flag can arrive in the same cycle. The bench provokes this on purpose. It asserts `local_fail_i` or `bus_fail_i` on the exact cycle that Normal mode is entered, and it fires a power-on event on that same entry cycle. Each outcome is then read through the error pin in a mode that selects the flag in question. For the failure flags, the clear must win. For the power-on event, the sets must survive.

// File: rtl/xcvr_flag_mgr.sv
module xcvr_flag_mgr #(
  parameter int DET_CYC = 16,
  parameter int REC_CYC = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       wake_evt_i,
  input  logic       wake_remote_i,
  input  logic       uv_supply_i,
  input  logic       pwon_evt_i,
  input  logic       bus_fail_i,
  input  logic       local_fail_i,
  input  logic       txd_i,
  input  logic       rxd_i,
  input  logic       stb_n_i,
  output logic       err_n_o,
  output logic       force_sleep_o,
  output logic       wake_o
);
  localparam logic [1:0] M_NRM = 2'd0;
  localparam logic [1:0] M_LSN = 2'd1;
  localparam logic [1:0] M_STB = 2'd2;
  localparam logic [1:0] M_SLP = 2'd3;
  localparam int DW = $clog2(DET_CYC + 1);
  localparam int RW = $clog2(REC_CYC + 1);
  localparam logic [DW-1:0] DET_LAST = DW'(DET_CYC - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);
  localparam logic [2:0] EDGE_LIM = 3'd4;

  logic [1:0]    mode_q, mode_eff;
  logic          txd_q, stb_q, lfn_q;
  logic [2:0]    edge_cnt;
  logic          f_wsrc, f_wake, f_bfail, f_lfail, f_pwon, f_uv;
  logic [DW-1:0] det_cnt;
  logic [RW-1:0] rec_cnt;
  logic          sel;

  assign mode_eff = f_uv ? M_SLP : mode_i;

  wire in_nrm      = (mode_eff == M_NRM);
  wire enter_nrm   = in_nrm && (mode_q != M_NRM);
  wire leave_nrm   = !in_nrm && (mode_q == M_NRM);
  wire lsn_from_n  = (mode_eff == M_LSN) && ((mode_q == M_NRM) || lfn_q);
  wire txd_rise    = txd_i && !txd_q;
  wire lf_resolved = !rxd_i && txd_i && !local_fail_i;
  wire stb_rise    = stb_n_i && !stb_q;
  wire uv_set      = uv_supply_i && !f_uv && (det_cnt == DET_LAST);
  wire rec_done    = !uv_supply_i && f_uv && (rec_cnt == REC_LAST);
  wire uv_clr      = wake_evt_i || pwon_evt_i || stb_rise || rec_done;

  always_comb begin
    case (mode_eff)
      M_NRM:   sel = (edge_cnt == EDGE_LIM) ? f_bfail : f_wsrc;
      M_LSN:   sel = lsn_from_n ? f_lfail : f_pwon;
      default: sel = f_wake;
    endcase
  end

  assign err_n_o       = !sel;
  assign force_sleep_o = f_uv;
  assign wake_o        = f_wake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_STB;
      txd_q    <= 1'b1;
      stb_q    <= 1'b1;
      lfn_q    <= 1'b0;
      edge_cnt <= '0;
    end else begin
      mode_q <= mode_eff;
      txd_q  <= txd_i;
      stb_q  <= stb_n_i;
      lfn_q  <= lsn_from_n;
      if (enter_nrm)
        edge_cnt <= '0;
      else if (in_nrm && txd_rise && edge_cnt != EDGE_LIM)
        edge_cnt <= edge_cnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_wsrc  <= 1'b0;
      f_wake  <= 1'b0;
      f_pwon  <= 1'b0;
      f_bfail <= 1'b0;
      f_lfail <= 1'b0;
    end else begin
      if (pwon_evt_i)                      f_wsrc <= 1'b1;
      else if (leave_nrm)                  f_wsrc <= 1'b0;
      else if (wake_evt_i && !wake_remote_i) f_wsrc <= 1'b1;

      if (pwon_evt_i)      f_wake <= 1'b1;
      else if (enter_nrm)  f_wake <= 1'b0;
      else if (wake_evt_i) f_wake <= 1'b1;

      if (pwon_evt_i)     f_pwon <= 1'b1;
      else if (enter_nrm) f_pwon <= 1'b0;

      if (pwon_evt_i || enter_nrm) f_bfail <= 1'b0;
      else if (bus_fail_i)         f_bfail <= 1'b1;

      if (pwon_evt_i || enter_nrm || lf_resolved) f_lfail <= 1'b0;
      else if (local_fail_i)                      f_lfail <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_uv    <= 1'b0;
      det_cnt <= '0;
      rec_cnt <= '0;
    end else begin
      if (uv_clr)      f_uv <= 1'b0;
      else if (uv_set) f_uv <= 1'b1;

      if (uv_clr || !uv_supply_i || f_uv) det_cnt <= '0;
      else                                det_cnt <= det_cnt + 1'b1;

      if (uv_clr || uv_supply_i || !f_uv) rec_cnt <= '0;
      else                                rec_cnt <= rec_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/xcvr_flag_mgr_chk.sv
module xcvr_flag_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_evt_i,
  input logic       pwon_evt_i,
  input logic       stb_n_i,
  input logic       force_sleep_o,
  input logic       wake_o,
  input logic [2:0] edge_cnt,
  input logic [1:0] mode_eff
);
  assert_edge_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= 3'd4);

  assert_forced_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    force_sleep_o |-> (mode_eff == 2'd3));

  assert_wake_clears_uv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt_i |=> !force_sleep_o);

  assert_stb_clears_uv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_n_i) |=> !force_sleep_o);

  assert_pwon_clears_uv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwon_evt_i |=> !force_sleep_o);

  assert_pwon_sets_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwon_evt_i |=> wake_o);
endmodule

bind xcvr_flag_mgr xcvr_flag_mgr_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wake_evt_i(wake_evt_i), .pwon_evt_i(pwon_evt_i),
  .stb_n_i(stb_n_i), .force_sleep_o(force_sleep_o), .wake_o(wake_o),
  .edge_cnt(edge_cnt), .mode_eff(mode_eff)
);

// File: tb/test_xcvr_flag_mgr.sv
module test_xcvr_flag_mgr;
  localparam int CLK_P = 10;
  localparam logic [1:0] NRM = 2'd0, LSN = 2'd1, STB = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = STB;
  logic wake = 0, remote = 0, uv = 0, pwon = 0, bfail = 0, lfail = 0;
  logic txd = 1, rxd = 1, stb_n = 1;
  logic err_n, fslp, wk;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  xcvr_flag_mgr #(.DET_CYC(4), .REC_CYC(6)) i_xcvr_flag_mgr (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wake_evt_i(wake), .wake_remote_i(remote),
    .uv_supply_i(uv), .pwon_evt_i(pwon), .bus_fail_i(bfail), .local_fail_i(lfail),
    .txd_i(txd), .rxd_i(rxd), .stb_n_i(stb_n),
    .err_n_o(err_n), .force_sleep_o(fslp), .wake_o(wk));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic txd_edge();
    txd = 0; tick(); txd = 1; tick();
  endtask

  task automatic t_reset();
    repeat (2) tick(); rst_n = 1; tick();
    chk(err_n, 1, "R1 err_n after reset");
    chk(fslp, 0, "R1 force_sleep after reset");
    chk(wk, 0, "R1 wake after reset");
  endtask

  task automatic t_normal_edges();
    wake = 1; remote = 0; tick(); wake = 0;
    chk(wk, 1, "R4 local wake sets wake flag");
    chk(err_n, 0, "R3 standby shows wake flag");
    mode = NRM; tick();
    chk(wk, 0, "R4 wake flag cleared on Normal entry");
    chk(err_n, 0, "R2 wake source shown before 4th edge");
    repeat (3) txd_edge();
    chk(err_n, 0, "R2 still wake source after 3 edges");
    txd_edge();
    chk(err_n, 1, "R2 bus failure shown after 4th edge");
    bfail = 1; tick(); bfail = 0;
    chk(err_n, 0, "R5 bus failure set");
    txd_edge();
    chk(err_n, 0, "R2 counter saturates");
    mode = LSN; tick();
    chk(err_n, 1, "R3 listen from Normal shows local failure");
    mode = NRM; tick();
    chk(err_n, 1, "R4 wake source cleared on leaving Normal");
    repeat (4) txd_edge();
    chk(err_n, 1, "R5 bus failure cleared on re-entry");
  endtask

  task automatic t_listen();
    mode = LSN; tick();
    lfail = 1; tick(); lfail = 0;
    chk(err_n, 0, "R6 local failure set");
    tick();
    chk(err_n, 0, "R6 held while rxd recessive");
    rxd = 0; tick(); rxd = 1;
    chk(err_n, 1, "R6 cleared by rxd dominant txd recessive");
    lfail = 1; tick(); lfail = 0;
    mode = NRM; lfail = 1; tick(); lfail = 0;
    mode = LSN; tick();
    chk(err_n, 1, "R10 Normal entry clear beats local failure set");
    mode = STB; tick();
    mode = NRM; bfail = 1; tick(); bfail = 0;
    repeat (4) txd_edge();
    chk(err_n, 1, "R10 Normal entry clear beats bus failure set");
  endtask

  task automatic t_pwon();
    mode = STB; tick();
    chk(wk, 0, "R3 wake flag clear in standby");
    pwon = 1; tick(); pwon = 0;
    chk(wk, 1, "R9 power-on sets wake flag");
    chk(err_n, 0, "R9 standby shows wake after power-on");
    mode = LSN; tick();
    chk(err_n, 0, "R3 listen from standby shows power-on flag");
    mode = NRM; tick();
    chk(err_n, 0, "R9 power-on set wake source");
    chk(wk, 0, "R4 wake cleared on entry");
    repeat (4) txd_edge();
    mode = LSN; tick();
    mode = STB; tick();
    mode = LSN; tick();
    chk(err_n, 1, "R9 power-on flag cleared on Normal entry");
    mode = NRM; tick();
    repeat (4) txd_edge();
    bfail = 1; tick(); bfail = 0;
    chk(err_n, 0, "R5 bus failure set before power-on");
    pwon = 1; tick(); pwon = 0;
    chk(err_n, 1, "R5 power-on clears bus failure");
    mode = STB; tick();
    mode = NRM; pwon = 1; tick(); pwon = 0;
    chk(wk, 1, "R9 power-on beats entry clear of wake");
    mode = STB; tick();
    mode = LSN; tick();
    chk(err_n, 0, "R9 power-on beats entry clear of power-on flag");
  endtask

  task automatic t_uv();
    mode = NRM; tick();
    mode = STB; tick();
    uv = 1; repeat (3) tick();
    chk(fslp, 0, "R7 not set before detection time");
    tick();
    chk(fslp, 1, "R7 set after detection time");
    uv = 0; mode = NRM; tick();
    chk(err_n, 1, "R7 forced sleep shows cleared wake flag");
    wake = 1; remote = 1; tick(); wake = 0;
    chk(fslp, 0, "R8 wake event clears undervoltage");
    chk(err_n, 1, "R4 remote wake leaves wake source clear");
    mode = STB; uv = 1; repeat (4) tick();
    chk(fslp, 1, "R7 set again");
    uv = 0; repeat (5) tick();
    chk(fslp, 1, "R8 held before recovery time");
    tick();
    chk(fslp, 0, "R8 cleared after recovery time");
    stb_n = 0; uv = 1; repeat (4) tick();
    chk(fslp, 1, "R7 set with standby pin low");
    stb_n = 1; tick(); uv = 0;
    chk(fslp, 0, "R8 standby pin rise clears undervoltage");
    uv = 1; repeat (4) tick();
    pwon = 1; tick(); pwon = 0; uv = 0;
    chk(fslp, 0, "R8 power-on clears undervoltage");
  endtask

  initial begin
    t_reset();
    t_normal_edges();
    t_listen();
    t_pwon();
    t_uv();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule